// File: doc/BRIEF.md
# Bit-Plane Importance-Adaptive ECC Encoder

This block accepts a group of `M` floating-point words in one transfer and replays the group as bit planes. Plane `i` carries bit `i` of every word in the group. Planes leave one per accepted transfer, starting with the most significant plane. Each plane is tagged critical when it holds sign or exponent bits and non-critical when it holds mantissa bits. The word format is fixed at elaboration: bfloat16, or an 8-bit float with 4 exponent bits and 3 mantissa bits.

Only critical planes feed the Reed-Solomon parity generator. The correction bandwidth therefore scales with the protected fraction of the word. For bfloat16 that fraction is 9 of 16 planes, and for the 8-bit format it is 5 of 8. Mantissa planes feed a CRC-16 detector or are left unprotected, as chosen by a mode input that is sampled with each group.

When the last plane has been accepted, a one-cycle summary strobe marks the finished parity and check value. Those values stay on the outputs until the next group is loaded. A memory controller write path would store the plane stream together with the parity and check value.

Top module: `bitplane_ecc_enc`

## Requirements
- R1: During and after an active-low reset, `in_ready_o` is 1, and `pl_valid_o`, `sum_valid_o` and `crc_valid_o` are 0. An assertion of reset in the middle of a stream drops the plane stream at once.
- R2: Word `k` of a group is `in_data_i[k*W +: W]`. Bit `k` of an emitted plane with index `i` equals bit `i` of word `k`.
- R3: After a group is accepted, planes appear with indices `W-1` down to 0, advancing one step per cycle in which both `pl_valid_o` and `pl_ready_i` are 1. `pl_last_o` is 1 only on index 0. `in_ready_o` stays 0 until the last plane is accepted.
- R4: `pl_crit_o` is 1 exactly for plane indices at or above the mantissa width. For bfloat16 these are planes 15..7, and for the 8-bit format planes 7..3.
- R5: While `pl_valid_o` is 1 and `pl_ready_i` is 0, `pl_data_o` and `pl_idx_o` hold their values.
- R6: `rs_par_o` is the remainder of (message × x^4) divided by g(x) = (x+1)(x+α)(x+α²)(x+α³) over GF(2^8), where α = 2 and the field polynomial is x^8+x^4+x^3+x^2+1. The message is the critical planes in emission order. Each plane is cut into `M/8` bytes, most significant byte first. `rs_par_o[31:24]` holds the x^3 coefficient and `rs_par_o[7:0]` the x^0 coefficient.
- R7: In check mode (`crc_en_i`=1 at load), `crc_o` is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR. It is computed over the non-critical planes in emission order, bit `M-1` of each plane first.
- R8: In unprotected mode (`crc_en_i`=0 at load), `crc_o` is 0 and `crc_valid_o` stays 0 for that group.
- R9: `sum_valid_o` is 1 for exactly the one cycle after the last plane is accepted. `rs_par_o` and `crc_o` keep their final values until the next group is loaded.
- R10: Only the value of `crc_en_i` at the load transfer counts. Changes while the group is streaming have no effect on that group's `crc_o` or `crc_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Group offered |
| in_ready_o | output | 1 | Block idle, group can be loaded |
| in_data_i | input | M*W | Group of M words, word k at bits k*W +: W |
| crc_en_i | input | 1 | 1 selects CRC on mantissa planes, 0 selects none |
| pl_valid_o | output | 1 | Plane valid |
| pl_ready_i | input | 1 | Plane accepted by sink |
| pl_data_o | output | M | Plane bits, bit k from word k |
| pl_idx_o | output | $clog2(W) | Bit position of this plane |
| pl_crit_o | output | 1 | Plane is sign/exponent (RS protected) |
| pl_last_o | output | 1 | Final plane of the group |
| sum_valid_o | output | 1 | One-cycle strobe: parity and check value final |
| rs_par_o | output | 32 | Four RS parity symbols, x^3 coefficient on top |
| crc_valid_o | output | 1 | Check value valid (check mode only) |
| crc_o | output | 16 | CRC-16 over mantissa planes, 0 when unprotected |

## Verification
A fault in the stored group or in the plane index shows up on the plane bus in the same cycle, as wrong bits or wrong tags. The first corrupted plane points to the bit position involved. A mis-clocked parity or CRC register does not show on the stream at all. It appears only at the summary strobe, `W` accepted transfers after the load, as a mismatch against the reference remainders. A fault in how the mode is latched appears there too: as a non-zero check value in unprotected mode, or as a check value that follows a mid-stream mode change. The bench rebuilds every word from the captured planes so that any transpose fault is traced back to a specific word.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  // GF(2^8) multiply, field polynomial x^8+x^4+x^3+x^2+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x, y;
    r = '0;
    x = a;
    y = b;
    for (int n = 0; n < 8; n++) begin
      if (y[0]) r = r ^ x;
      y = y >> 1;
      x = x[7] ? ((x << 1) ^ 8'h1d) : (x << 1);
    end
    return r;
  endfunction

  // generator with roots alpha^0..alpha^3, returns {c3,c2,c1,c0} (monic x^4 implied)
  function automatic logic [31:0] rs_gen();
    logic [4:0][7:0] c;
    logic [7:0] root;
    c = '0;
    c[0] = 8'h01;
    root = 8'h01;
    for (int r = 0; r < 4; r++) begin
      for (int k = 4; k >= 0; k--) begin
        c[k] = ((k > 0) ? c[k-1] : 8'h00) ^ gf_mul(c[k], root);
      end
      root = gf_mul(root, 8'h02);
    end
    return {c[3], c[2], c[1], c[0]};
  endfunction

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hffff;

endpackage

// File: rtl/bpe_plane_sel.sv
module bpe_plane_sel #(
  parameter int W  = 16,
  parameter int M  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [M*W-1:0] grp_i,
  input  logic [IW-1:0]  idx_i,
  output logic [M-1:0]   plane_o
);
  for (genvar k = 0; k < M; k++) begin : g_word
    logic [W-1:0] word;
    assign word       = grp_i[k*W +: W];
    assign plane_o[k] = word[idx_i];
  end
endmodule

// File: rtl/bpe_rs_par.sv
module bpe_rs_par #(
  parameter int M = 64,
  localparam int SYMS = M / 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [M-1:0] data_i,
  output logic [31:0]  par_o
);
  import bpe_pkg::*;
  localparam logic [31:0] G = rs_gen();

  logic [3:0][7:0] par_q, par_d;

  // SYMS symbols per plane, most significant byte first
  always_comb begin
    logic [3:0][7:0] p;
    logic [7:0] d, fb;
    p = par_q;
    for (int s = 0; s < SYMS; s++) begin
      d    = data_i[M-1-8*s -: 8];
      fb   = d ^ p[3];
      p[3] = p[2] ^ gf_mul(fb, G[31:24]);
      p[2] = p[1] ^ gf_mul(fb, G[23:16]);
      p[1] = p[0] ^ gf_mul(fb, G[15:8]);
      p[0] = gf_mul(fb, G[7:0]);
    end
    par_d = p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    par_q <= '0;
    else if (clr_i) par_q <= '0;
    else if (en_i)  par_q <= par_d;
  end

  assign par_o = par_q;
endmodule

// File: rtl/bpe_crc16.sv
module bpe_crc16 #(
  parameter int M = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [M-1:0] data_i,
  output logic [15:0]  crc_o
);
  import bpe_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    logic [15:0] c;
    logic fb;
    c = crc_q;
    for (int b = M - 1; b >= 0; b--) begin
      fb = c[15] ^ data_i[b];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    crc_d = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (en_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/bitplane_ecc_enc.sv
module bitplane_ecc_enc #(
  parameter bit FMT_FP8 = 1'b0,
  parameter int M       = 64,
  localparam int W      = FMT_FP8 ? 8 : 16,
  localparam int MANT   = FMT_FP8 ? 3 : 7,
  localparam int IW     = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [M*W-1:0] in_data_i,
  input  logic           crc_en_i,
  output logic           pl_valid_o,
  input  logic           pl_ready_i,
  output logic [M-1:0]   pl_data_o,
  output logic [IW-1:0]  pl_idx_o,
  output logic           pl_crit_o,
  output logic           pl_last_o,
  output logic           sum_valid_o,
  output logic [31:0]    rs_par_o,
  output logic           crc_valid_o,
  output logic [15:0]    crc_o
);
  localparam logic [IW-1:0] MANT_IDX = IW'(MANT);
  localparam logic [IW-1:0] TOP_IDX  = IW'(W - 1);

  logic [M*W-1:0] grp_q;
  logic [IW-1:0]  idx_q;
  logic           busy_q, done_q, crc_en_q;
  logic           load, xfer, crit, last;
  logic [15:0]    crc_raw;

  assign load = in_valid_i && !busy_q;
  assign xfer = busy_q && pl_ready_i;
  assign crit = idx_q >= MANT_IDX;
  assign last = idx_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q    <= '0;
      idx_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      crc_en_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        grp_q    <= in_data_i;
        idx_q    <= TOP_IDX;
        busy_q   <= 1'b1;
        crc_en_q <= crc_en_i;
      end else if (xfer) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  bpe_plane_sel #(.W(W), .M(M)) u_sel (
    .grp_i  (grp_q),
    .idx_i  (idx_q),
    .plane_o(pl_data_o)
  );

  bpe_rs_par #(.M(M)) u_rs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .en_i  (xfer && crit),
    .data_i(pl_data_o),
    .par_o (rs_par_o)
  );

  bpe_crc16 #(.M(M)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .en_i  (xfer && !crit && crc_en_q),
    .data_i(pl_data_o),
    .crc_o (crc_raw)
  );

  assign in_ready_o  = !busy_q;
  assign pl_valid_o  = busy_q;
  assign pl_idx_o    = idx_q;
  assign pl_crit_o   = busy_q && crit;
  assign pl_last_o   = busy_q && last;
  assign sum_valid_o = done_q;
  assign crc_valid_o = done_q && crc_en_q;
  assign crc_o       = crc_en_q ? crc_raw : 16'h0000;
endmodule

// File: rtl/bitplane_ecc_enc_chk.sv
module bitplane_ecc_enc_chk #(
  parameter int W  = 16,
  parameter int M  = 64,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          pl_valid_o,
  input logic          pl_ready_i,
  input logic [M-1:0]  pl_data_o,
  input logic [IW-1:0] pl_idx_o,
  input logic          pl_crit_o,
  input logic          pl_last_o,
  input logic          sum_valid_o,
  input logic          crc_valid_o,
  input logic [15:0]   crc_o
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !pl_valid_o);

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> pl_valid_o && (pl_idx_o == IW'(W - 1)) && pl_crit_o);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o && pl_ready_i && !pl_last_o |=> pl_valid_o && (pl_idx_o == $past(pl_idx_o) - 1'b1));

  p_tail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o && pl_last_o |-> !pl_crit_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o && !pl_ready_i |=> pl_valid_o && $stable(pl_data_o) && $stable(pl_idx_o));

  p_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o && !crc_valid_o |-> crc_o == 16'h0000);

  p_cval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_valid_o |-> sum_valid_o);

  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o && pl_ready_i && pl_last_o |=> sum_valid_o && in_ready_o);

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |=> !sum_valid_o);
endmodule

bind bitplane_ecc_enc bitplane_ecc_enc_chk #(.W(W), .M(M), .IW(IW)) chk_i (.*);

// File: tb/bitplane_ecc_enc_tb_top.sv
module bitplane_ecc_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int M    = 64;
  localparam int W    = 16;
  localparam int MANT = 7;
  localparam int IW   = 4;
  localparam int NB   = (W - MANT) * M / 8;
  localparam int NVEC = 6;

  // {kind[35:34], crc mode[33], stall[32], seed[31:0]}; kind 0 random, 1 zeros, 2 ones, 3 checker
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b0, 32'h1234_5678},
    {2'd0, 1'b1, 1'b1, 32'hdead_beef},
    {2'd1, 1'b1, 1'b0, 32'h0000_0000},
    {2'd2, 1'b1, 1'b1, 32'h0000_0001},
    {2'd3, 1'b0, 1'b0, 32'h0000_0002},
    {2'd0, 1'b0, 1'b1, 32'hcafe_f00d}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           in_valid_i = 1'b0;
  logic           in_ready_o;
  logic [M*W-1:0] in_data_i = '0;
  logic           crc_en_i = 1'b0;
  logic           pl_valid_o;
  logic           pl_ready_i = 1'b0;
  logic [M-1:0]   pl_data_o;
  logic [IW-1:0]  pl_idx_o;
  logic           pl_crit_o, pl_last_o, sum_valid_o, crc_valid_o;
  logic [31:0]    rs_par_o;
  logic [15:0]    crc_o;

  bitplane_ecc_enc #(.FMT_FP8(1'b0), .M(M)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  logic [W-1:0] vals [M];
  logic [W-1:0] rec  [M];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int n = 7; n >= 0; n--) begin
      r = r[7] ? ((r << 1) ^ 8'h1d) : (r << 1);
      if (b[n]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] plane_of(input int i);
    logic [M-1:0] p;
    for (int k = 0; k < M; k++) p[k] = vals[k][i];
    return p;
  endfunction

  function automatic logic [31:0] ref_rs();
    logic [7:0] g [5];
    logic [7:0] arr [NB + 4];
    logic [7:0] root = 8'h01;
    logic [M-1:0] pl;
    int n = 0;
    // g[0] leading coefficient, descending powers
    g[0] = 8'h01;
    for (int j = 1; j < 5; j++) g[j] = 8'h00;
    for (int r = 0; r < 4; r++) begin
      for (int j = 4; j >= 1; j--) g[j] = g[j] ^ gmul(g[j-1], root);
      root = gmul(root, 8'h02);
    end
    for (int i = W - 1; i >= MANT; i--) begin
      pl = plane_of(i);
      for (int s = 0; s < M / 8; s++) begin
        arr[n] = pl[M-1-8*s -: 8];
        n++;
      end
    end
    for (int j = 0; j < 4; j++) arr[NB + j] = 8'h00;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] c = arr[i];
      for (int j = 1; j < 5; j++) arr[i + j] = arr[i + j] ^ gmul(g[j], c);
    end
    return {arr[NB], arr[NB + 1], arr[NB + 2], arr[NB + 3]};
  endfunction

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'hffff;
    logic [M-1:0] pl;
    for (int i = MANT - 1; i >= 0; i--) begin
      pl = plane_of(i);
      for (int b = M - 1; b >= 0; b--) begin
        logic fb = c[15] ^ pl[b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic fill(input int kind, input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int k = 0; k < M; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      case (kind)
        0: vals[k] = s[31 -: W];
        1: vals[k] = '0;
        2: vals[k] = '1;
        default: vals[k] = k[0] ? 16'h5555 : 16'haaaa;
      endcase
      in_data_i[k*W +: W] = vals[k];
    end
  endtask

  task automatic run_group(input int kind, input logic [31:0] seed, input bit mode,
                           input bit stall, input bit flip);
    logic [31:0] exp_rs;
    logic [15:0] exp_crc;
    logic [M-1:0] prev_data;
    logic [IW-1:0] prev_idx;
    bit have_prev = 1'b0;
    int got = 0;
    int cyc = 0;
    int exp_idx = W - 1;
    int miss = 0;
    fill(kind, seed);
    exp_rs  = ref_rs();
    exp_crc = ref_crc();
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R3 idle before load", 64'(in_ready_o), 64'd1);
    in_valid_i = 1'b1;
    crc_en_i   = mode;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_data_i  = '0;
    while (got < W) begin
      if (have_prev)
        chk(pl_data_o == prev_data && pl_idx_o == prev_idx, "R5 hold under stall",
            64'(pl_idx_o), 64'(prev_idx));
      chk(pl_valid_o && !in_ready_o, "R3 streaming flags", {pl_valid_o, in_ready_o}, 64'h2);
      chk(pl_idx_o == IW'(exp_idx), "R3 plane order", 64'(pl_idx_o), 64'(exp_idx));
      chk(pl_crit_o == (exp_idx >= MANT), "R4 plane tag", 64'(pl_crit_o), 64'(exp_idx >= MANT));
      chk(pl_last_o == (exp_idx == 0), "R3 last flag", 64'(pl_last_o), 64'(exp_idx == 0));
      pl_ready_i = stall ? (cyc % 3 != 1) : 1'b1;
      if (flip && cyc == 3) crc_en_i = !mode;
      if (pl_ready_i) begin
        for (int k = 0; k < M; k++) rec[k][exp_idx] = pl_data_o[k];
        got++;
        exp_idx--;
        have_prev = 1'b0;
      end else begin
        have_prev = 1'b1;
        prev_data = pl_data_o;
        prev_idx  = pl_idx_o;
      end
      cyc++;
      @(negedge clk_i);
    end
    pl_ready_i = 1'b0;
    for (int k = 0; k < M; k++) if (rec[k] != vals[k]) miss++;
    chk(miss == 0, "R2 transpose round trip", 64'(miss), 64'd0);
    chk(sum_valid_o == 1'b1 && pl_valid_o == 1'b0, "R9 summary strobe",
        {sum_valid_o, pl_valid_o}, 64'h2);
    chk(rs_par_o == exp_rs, "R6 RS parity", 64'(rs_par_o), 64'(exp_rs));
    if (mode) chk(crc_o == exp_crc, "R7 CRC-16", 64'(crc_o), 64'(exp_crc));
    else      chk(crc_o == 16'h0, "R8 no-protect CRC zero", 64'(crc_o), 64'd0);
    chk(crc_valid_o == mode, flip ? "R10 mode latched at load" : "R8 CRC valid by mode",
        64'(crc_valid_o), 64'(mode));
    @(negedge clk_i);
    chk(sum_valid_o == 1'b0, "R9 one-cycle strobe", 64'(sum_valid_o), 64'd0);
    @(negedge clk_i);
    chk(rs_par_o == exp_rs && crc_o == (mode ? exp_crc : 16'h0), "R9 results held",
        64'(rs_par_o), 64'(exp_rs));
    crc_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(in_ready_o && !pl_valid_o && !sum_valid_o && !crc_valid_o, "R1 reset state",
        {in_ready_o, pl_valid_o, sum_valid_o, crc_valid_o}, 64'h8);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o && !pl_valid_o && !sum_valid_o, "R1 after release",
        {in_ready_o, pl_valid_o, sum_valid_o}, 64'h4);

    for (int v = 0; v < NVEC; v++)
      run_group(int'(VEC[v][35:34]), VEC[v][31:0], VEC[v][33], VEC[v][32], 1'b0);

    // R10: mode toggled mid-stream in both directions
    run_group(0, 32'h0bad_cafe, 1'b1, 1'b0, 1'b1);
    run_group(0, 32'h7777_1111, 1'b0, 1'b1, 1'b1);

    // R1: reset in the middle of a stream
    fill(0, 32'h4242_4242);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    crc_en_i   = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    pl_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pl_ready_i = 1'b0;
    rst_ni     = 1'b0;
    #1;
    chk(in_ready_o && !pl_valid_o && !sum_valid_o && !crc_valid_o, "R1 mid-stream reset",
        {in_ready_o, pl_valid_o, sum_valid_o, crc_valid_o}, 64'h8);
    @(negedge clk_i);
    rst_ni = 1'b1;
    crc_en_i = 1'b0;
    run_group(3, 32'h0, 1'b1, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule